// File: doc/BRIEF.md
# Error Status and Mask Unit

This block gathers thirteen error events from a bus bridge and its message unit into a sticky status register. Software clears a status bit by writing 1 to it. An active-high mask register decides which recorded events may reach the local processor. The processor sees two registered outputs: an ordinary interrupt and a machine check.

Most sources feed the interrupt. The doorbell source always feeds the machine check. The general-error source goes to one output or the other, depending on a control bit. A masked source is still recorded in the status register, but it raises neither output.

Event inputs are single-cycle pulses. A small register port selects one of three registers. Reads are combinational. Writes are committed on the clock edge.

Top module: `err_status_unit`

## Requirements
- R1: After reset, status, mask and control read as zero, and `irq_o` and `mcp_o` are low.
- R2: A pulse on a source sets its status bit. The bit stays set until software clears it. Status bit positions are:
  - bit 0: address parity
  - bit 1: write data parity
  - bit 2: read data parity
  - bit 3: master abort
  - bit 4: target abort
  - bit 5: SERR received
  - bit 6: reported read parity
  - bit 7: reported write parity
  - bit 8: outbound free queue overflow
  - bit 9: inbound post queue overflow
  - bit 10: illegal-size access
  - bit 11: general error
  - bit 12: doorbell
- R3: A write to the status register (select 0) clears each bit written as 1. Bits written as 0 are unchanged.
- R4: An event that arrives in the same cycle as a clear of its bit wins, so the bit stays set.
- R5: A source whose mask bit is 0 is recorded in status but raises neither output.
- R6: `irq_o` is the OR of unmasked status bits 0 through 10, together with bit 11 when control bit 11 is 0.
- R7: When control bit 11 is 1, status bit 11 drives `mcp_o` instead of `irq_o`. Control is written at select 2.
- R8: A doorbell pulse sets status bit 12. When mask bit 12 is set, status bit 12 drives `mcp_o` and never `irq_o`.
- R9: An inbound post queue overflow (bit 9) or an outbound free queue overflow (bit 8) also sets bit 12. This happens only while the matching enable input is high.
- R10: Status bits 31..13, mask bits 31..13 and every control bit except 11 read as zero. Select 3 reads zero. The mask register is written at select 1.
- R11: `irq_o` and `mcp_o` change one clock edge after the status, mask or control change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | 12 | Event pulses for status bits 11..0 |
| db_hit_i | input | 1 | Doorbell write with its top bit set |
| ipq_mc_en_i | input | 1 | Lets an inbound post queue overflow set bit 12 |
| ofq_mc_en_i | input | 1 | Lets an outbound free queue overflow set bit 12 |
| reg_sel_i | input | 2 | Register select: 0 status, 1 mask, 2 control |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt to the processor |
| mcp_o | output | 1 | Machine check to the processor |

## Verification
An event, or a register write, is captured on the rising edge that samples it. Its status or register readback is therefore visible from the following falling edge. `irq_o` and `mcp_o` follow one rising edge later.

The bench drives inputs on falling edges. A behavioural model advances on each rising edge, and both outputs are compared with the model at every falling edge. Directed checks read registers just after a falling edge. They test each output level at the edge where it is due, and also the edge just before it.

// File: rtl/esu_pkg.sv
package esu_pkg;
  localparam int unsigned NUM_EVT = 13;
  localparam int unsigned BIT_OFQ = 8;
  localparam int unsigned BIT_IPQ = 9;
  localparam int unsigned BIT_GEN = 11;
  localparam int unsigned BIT_DB  = 12;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/esu_sticky.sv
module esu_sticky #(
  parameter int unsigned N = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // new event beats clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/esu_route.sv
module esu_route #(
  parameter int unsigned N       = 13,
  parameter int unsigned GEN_BIT = 11,
  parameter int unsigned DB_BIT  = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  input  logic         gen_to_mc_i,
  output logic         irq_o,
  output logic         mcp_o
);
  logic [N-1:0] active;
  logic [N-1:0] to_irq;
  logic [N-1:0] to_mc;

  assign active = status_i & mask_i;

  for (genvar i = 0; i < N; i++) begin : g_route
    if (i == DB_BIT) begin : g_db
      assign to_irq[i] = 1'b0;
      assign to_mc[i]  = active[i];
    end else if (i == GEN_BIT) begin : g_gen
      assign to_irq[i] = active[i] & ~gen_to_mc_i;
      assign to_mc[i]  = active[i] &  gen_to_mc_i;
    end else begin : g_std
      assign to_irq[i] = active[i];
      assign to_mc[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      mcp_o <= 1'b0;
    end else begin
      irq_o <= |to_irq;
      mcp_o <= |to_mc;
    end
  end
endmodule

// File: rtl/esu_regif.sv
module esu_regif
  import esu_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned N       = 13,
  parameter int unsigned GEN_BIT = 11
) (
  input  reg_sel_e      sel_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  status_i,
  input  logic [N-1:0]  mask_i,
  input  logic          ctrl_i,
  output logic [N-1:0]  clr_o,
  output logic          mask_we_o,
  output logic          ctrl_we_o,
  output logic [DW-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign clr_o     = (we_i && sel_i == SEL_STATUS) ? wdata_i[N-1:0] : '0;
  assign mask_we_o = we_i && sel_i == SEL_MASK;
  assign ctrl_we_o = we_i && sel_i == SEL_CTRL;

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_STATUS: rdata_o[N-1:0]  = status_i;
      SEL_MASK:   rdata_o[N-1:0]  = mask_i;
      SEL_CTRL:   rdata_o[GEN_BIT] = ctrl_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/err_status_unit.sv
module err_status_unit
  import esu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-2:0]   src_pulse_i,
  input  logic                 db_hit_i,
  input  logic                 ipq_mc_en_i,
  input  logic                 ofq_mc_en_i,
  input  logic [SEL_W-1:0]     reg_sel_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic                 mcp_o
);
  localparam int unsigned N = NUM_EVT;

  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] status_q;
  logic [N-1:0] mask_q;
  logic         ctrl_q;
  logic         mask_we;
  logic         ctrl_we;
  logic         db_set;

  assign db_set = db_hit_i
                | (src_pulse_i[BIT_IPQ] & ipq_mc_en_i)
                | (src_pulse_i[BIT_OFQ] & ofq_mc_en_i);
  assign set_vec = {db_set, src_pulse_i};

  esu_sticky #(.N(N)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (status_q)
  );

  esu_regif #(.DW(DATA_W), .N(N), .GEN_BIT(BIT_GEN)) u_regif (
    .sel_i     (reg_sel_e'(reg_sel_i)),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (status_q),
    .mask_i    (mask_q),
    .ctrl_i    (ctrl_q),
    .clr_o     (clr_vec),
    .mask_we_o (mask_we),
    .ctrl_we_o (ctrl_we),
    .rdata_o   (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ctrl_q <= 1'b0;
    end else begin
      if (mask_we) mask_q <= reg_wdata_i[N-1:0];
      if (ctrl_we) ctrl_q <= reg_wdata_i[BIT_GEN];
    end
  end

  esu_route #(.N(N), .GEN_BIT(BIT_GEN), .DB_BIT(BIT_DB)) u_route (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .status_i    (status_q),
    .mask_i      (mask_q),
    .gen_to_mc_i (ctrl_q),
    .irq_o       (irq_o),
    .mcp_o       (mcp_o)
  );
endmodule

// File: rtl/esu_checker.sv
module esu_checker
  import esu_pkg::*;
#(
  parameter int unsigned N  = 13,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  mask_q,
  input logic          ctrl_q,
  input logic [N-1:0]  set_vec,
  input logic [N-1:0]  clr_vec,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_o,
  input logic          mcp_o
);
  a_r2_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(clr_vec)) & ~status_q) == '0));

  a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_vec) & ~status_q) == '0));

  a_r5_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> (!irq_o && !mcp_o));

  a_r7_gen_to_mc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[BIT_GEN] && mask_q[BIT_GEN] && ctrl_q) |=> mcp_o);

  a_r6_gen_to_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[BIT_GEN] && mask_q[BIT_GEN] && !ctrl_q) |=> irq_o);

  a_r8_db_mc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[BIT_DB] && mask_q[BIT_DB]) |=> mcp_o);

  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DW-1:N] == '0);
endmodule

bind err_status_unit esu_checker #(.N(esu_pkg::NUM_EVT), .DW(DATA_W)) u_esu_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .ctrl_q      (ctrl_q),
  .set_vec     (set_vec),
  .clr_vec     (clr_vec),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .mcp_o       (mcp_o)
);

// File: tb/test_err_status_unit.sv
`timescale 1ns/1ps
module test_err_status_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] src = '0;
  logic        db = 1'b0, ipq_en = 1'b0, ofq_en = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, mcp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_status_unit i_err_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .src_pulse_i(src), .db_hit_i(db),
    .ipq_mc_en_i(ipq_en), .ofq_mc_en_i(ofq_en), .reg_sel_i(sel),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .mcp_o(mcp)
  );

  // behavioural reference
  logic [12:0] m_st, m_mk;
  logic        m_ct, m_irq, m_mcp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0; m_mk = '0; m_ct = 1'b0; m_irq = 1'b0; m_mcp = 1'b0;
    end else begin
      logic [12:0] s, c;
      m_irq = (|(m_st[10:0] & m_mk[10:0])) | (m_st[11] & m_mk[11] & ~m_ct);
      m_mcp = (m_st[12] & m_mk[12]) | (m_st[11] & m_mk[11] & m_ct);
      s = {db | (src[9] & ipq_en) | (src[8] & ofq_en), src};
      c = (we && sel == 2'd0) ? wdata[12:0] : 13'd0;
      m_st = s | (m_st & ~c);
      if (we && sel == 2'd1) m_mk = wdata[12:0];
      if (we && sel == 2'd2) m_ct = wdata[11];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] s);
    case (s)
      2'd0: exp_rd = {19'd0, m_st};
      2'd1: exp_rd = {19'd0, m_mk};
      2'd2: exp_rd = {20'd0, m_ct, 11'd0};
      default: exp_rd = '0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // R11: outputs against model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq === m_irq, "R11 irq", {31'd0, irq}, {31'd0, m_irq});
      chk(mcp === m_mcp, "R11 mcp", {31'd0, mcp}, {31'd0, m_mcp});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    sel = s; wdata = d; we = 1'b1;
    tick();
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [11:0] p, input logic d);
    src = p; db = d;
    tick();
    src = '0; db = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string tag);
    sel = s;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic out_chk(input logic ei, input logic em, input string tag);
    chk(irq === ei, {tag, " irq"}, {31'd0, irq}, {31'd0, ei});
    chk(mcp === em, {tag, " mcp"}, {31'd0, mcp}, {31'd0, em});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    rd_chk(2'd0, 32'h0, "R1 status");
    rd_chk(2'd1, 32'h0, "R1 mask");
    rd_chk(2'd2, 32'h0, "R1 ctrl");
    out_chk(1'b0, 1'b0, "R1");

    // R5: masked event recorded, outputs quiet
    pulse(12'h008, 1'b0);
    rd_chk(2'd0, 32'h8, "R5 status");
    tick(); tick();
    out_chk(1'b0, 1'b0, "R5");

    // R2: sticky
    repeat (4) tick();
    rd_chk(2'd0, 32'h8, "R2 sticky");

    // R6 / R11: unmask sources 0..10
    wr(2'd1, 32'h7FF);
    out_chk(1'b0, 1'b0, "R11 before");
    tick();
    out_chk(1'b1, 1'b0, "R6");

    // R3: W1C
    wr(2'd0, 32'h0);
    rd_chk(2'd0, 32'h8, "R3 zero write");
    wr(2'd0, 32'h8);
    rd_chk(2'd0, 32'h0, "R3 clear");
    tick();
    out_chk(1'b0, 1'b0, "R3");

    // R4: event beats same-cycle clear
    src = 12'h020; sel = 2'd0; wdata = 32'h20; we = 1'b1;
    tick();
    src = '0; we = 1'b0; wdata = '0;
    rd_chk(2'd0, 32'h20, "R4 stays set");
    wr(2'd0, 32'h20);
    rd_chk(2'd0, 32'h0, "R4 cleared");

    // R7: general error routing
    wr(2'd1, 32'h1FFF);
    pulse(12'h800, 1'b0);
    tick();
    out_chk(1'b1, 1'b0, "R6 gen irq");
    wr(2'd2, 32'h800);
    rd_chk(2'd2, 32'h800, "R7 ctrl");
    tick();
    out_chk(1'b0, 1'b1, "R7");
    wr(2'd0, 32'h1FFF);
    wr(2'd2, 32'h0);

    // R8: doorbell
    pulse(12'h000, 1'b1);
    rd_chk(2'd0, 32'h1000, "R8 status");
    tick();
    out_chk(1'b0, 1'b1, "R8");
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h0FFF);
    pulse(12'h000, 1'b1);
    rd_chk(2'd0, 32'h1000, "R5 db masked status");
    tick();
    out_chk(1'b0, 1'b0, "R5 db masked");
    wr(2'd0, 32'h1FFF);
    wr(2'd1, 32'h1FFF);

    // R9: queue overflow into bit 12
    pulse(12'h200, 1'b0);
    rd_chk(2'd0, 32'h200, "R9 ipq disabled");
    wr(2'd0, 32'h1FFF);
    ipq_en = 1'b1;
    pulse(12'h200, 1'b0);
    rd_chk(2'd0, 32'h1200, "R9 ipq enabled");
    ipq_en = 1'b0;
    wr(2'd0, 32'h1FFF);
    ofq_en = 1'b1;
    pulse(12'h100, 1'b0);
    rd_chk(2'd0, 32'h1100, "R9 ofq enabled");
    ofq_en = 1'b0;
    wr(2'd0, 32'h1FFF);

    // R10: reserved bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd_chk(2'd1, 32'h1FFF, "R10 mask");
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk(2'd2, 32'h800, "R10 ctrl");
    pulse(12'hFFF, 1'b0);
    rd_chk(2'd0, 32'h0FFF, "R10 status");
    rd_chk(2'd3, 32'h0, "R10 none");
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk(2'd0, 32'h0, "R3 clear all");

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [1:0] s;
      s = 2'($urandom);
      rd_chk(s, exp_rd(s), "R2 model read");
      src = 12'($urandom & $urandom & $urandom);
      db = ($urandom % 10) == 0;
      ipq_en = 1'($urandom);
      ofq_en = 1'($urandom);
      we = ($urandom % 4) == 0;
      wdata = $urandom;
      tick();
    end
    src = '0; db = 1'b0; we = 1'b0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule